// File: doc/BRIEF.md
# Event-Driven Transition-Table Executor

This block runs a state machine whose behaviour is not fixed in logic but held as a compact transition table in an on-block program store of two banks. It keeps a current state label and fetches that state's list pointer from a state table. It then idles until any hardware event line is raised, takes a snapshot of the event vector, and walks the state's transition records in order. Each record names an event bit and a condition. An outside evaluator judges the condition, and the first record whose event bit is set and whose condition holds wins. The engine then offers the record's action code and argument on a valid/acknowledge port, and moves to the record's next state once the action is acknowledged.

A host writes a new program into whichever bank is not running and then requests activation. The swap happens only when the engine sits idle between transitions, and execution restarts from the initial state named by the new bank. Program words are 16 bits. Word 0 of a bank holds the initial state label, and word 1+s holds the list pointer of state s. A list pointer carries the list's word address in bits [4+AW-1:4], a scan-mode flag in bit 3 and (count-1) in bits [2:0]. Each transition record is three consecutive words: {event index, next state}, {condition argument, action code}, {action argument}.

Top module: `xfsm_exec`

## Requirements
- R1: During and directly after reset act_valid is 0 and bank 0 is the running bank (act_bank = 0).
- R2: After a bank starts running, cur_state equals the low 8 bits of word 0 of that bank before the first event is handled.
- R3: With pointer bit 3 clear, only the first (bits[2:0]+1) records of the list are examined; a matching record placed after them is never taken.
- R4: With pointer bit 3 set, records are examined past the eighth until a first word equal to 0xFFFF; a record beyond that delimiter is never taken.
- R5: Records are examined in list order, and the first with its event bit (vector bit selected by the low bits of word0[15:8]) set and its condition true is taken.
- R6: A record whose event bit is set but whose condition input is false during its evaluation (cond_sel = word0[15:8], cond_arg = word1[15:8]) is skipped.
- R7: An event with no matching record produces no action and leaves cur_state unchanged; the next event restarts the scan at the first record.
- R8: A taken record raises act_valid with act_id = word1[7:0] and act_par = word2; these hold steady and cur_state does not change until act_ack, after which cur_state becomes word0[7:0].
- R9: Event lines raised while an action is pending are not sampled and cause no later action.
- R10: Host writes go to the bank that is not running and do not alter the running program.
- R11: An activation request takes effect only while the engine is idle; a request made during a pending action is held and applied after it, and execution then restarts from the new bank's initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | EVW | Hardware event lines |
| cond_sel | output | 8 | Condition selector of the record under test |
| cond_arg | output | 8 | Condition argument of the record under test |
| cond_ok | input | 1 | Condition result for cond_sel/cond_arg, same cycle |
| act_valid | output | 1 | Action request pending |
| act_ack | input | 1 | Action accepted |
| act_id | output | 8 | Action code |
| act_par | output | 16 | Action argument |
| host_we | input | 1 | Host program write strobe |
| host_addr | input | AW | Host write word address |
| host_wdata | input | 16 | Host write data |
| host_activate | input | 1 | Request to run the freshly written bank |
| act_bank | output | 1 | Bank currently running |
| cur_state | output | 8 | Current state label |
| idle | output | 1 | Engine waiting for an event |

## Verification
Two functions can meet in one cycle: a pending action and a host activation request, and a pending action and fresh event lines. The bench holds the acknowledge back for several cycles, raises both activation and an event that would match while act_valid is high, and judges that the running bank stays unchanged, that the stray event yields no action, and that the swap and the restart from the new initial state follow only after the acknowledge.

// File: rtl/xfsm_pkg.sv
// Shared constants and types of the transition-table executor.
// Assumes 16-bit program words and 8-bit state labels.
package xfsm_pkg;
    localparam int WORD_W  = 16;
    localparam int LABEL_W = 8;
    localparam logic [WORD_W-1:0] LIST_END = 16'hFFFF;

    typedef enum logic [3:0] {
        E_INIT_RD,
        E_INIT_WT,
        E_PTR_RD,
        E_PTR_WT,
        E_IDLE,
        E_F0,
        E_F1,
        E_F2,
        E_EVAL,
        E_ACT
    } eng_st_t;
endpackage

// File: rtl/xfsm_progmem.sv
// Two-bank program store. One port writes, one port reads with one
// cycle of latency. Assumes the caller keeps write and read banks apart.
module xfsm_progmem #(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int NB = 2
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [$clog2(NB)-1:0] wbank,
    input  logic [AW-1:0]         waddr,
    input  logic [DW-1:0]         wdata,
    input  logic [$clog2(NB)-1:0] rbank,
    input  logic [AW-1:0]         raddr,
    output logic [DW-1:0]         rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [NB][DEPTH];

    // Host write into the selected bank.
    always_ff @(posedge clk) begin
        if (we) mem[wbank][waddr] <= wdata;
    end

    // Registered read from the running bank.
    always_ff @(posedge clk) begin
        rdata <= mem[rbank][raddr];
    end
endmodule

// File: rtl/xfsm_bank_ctl.sv
// Tracks which bank runs and holds an activation request until the
// engine reports it is taking it (sw_go, only issued while idle).
module xfsm_bank_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic activate,
    input  logic sw_go,
    output logic act_bank,
    output logic sw_pend
);
    // Pending request flag; a new request wins over a concurrent take.
    always_ff @(posedge clk) begin
        if (!rst_n)        sw_pend <= 1'b0;
        else if (activate) sw_pend <= 1'b1;
        else if (sw_go)    sw_pend <= 1'b0;
    end

    // Running bank flips when the engine takes the request.
    always_ff @(posedge clk) begin
        if (!rst_n)     act_bank <= 1'b0;
        else if (sw_go) act_bank <= ~act_bank;
    end
endmodule

// File: rtl/xfsm_engine.sv
// Walks the transition table. Loads the initial state, fetches the state
// pointer, waits for events, scans records (count- or delimiter-bounded)
// and issues the first matching action through a valid/ack handshake.
// Assumes a one-cycle read latency on rdata and AW <= 11.
module xfsm_engine
    import xfsm_pkg::*;
#(
    parameter int AW  = 8,
    parameter int EVW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVW-1:0]     evt_in,
    input  logic               cond_ok,
    input  logic               act_ack,
    input  logic               sw_pend,
    input  logic [WORD_W-1:0]  rdata,
    output logic [AW-1:0]      rd_addr,
    output logic               sw_go,
    output logic [7:0]         cond_sel,
    output logic [7:0]         cond_arg,
    output logic               act_valid,
    output logic [7:0]         act_id,
    output logic [WORD_W-1:0]  act_par,
    output logic [LABEL_W-1:0] cur_state,
    output logic               idle
);
    localparam int EVB = (EVW > 1) ? $clog2(EVW) : 1;

    eng_st_t             st;
    logic [AW-1:0]       list_base;
    logic                delim_mode;
    logic [2:0]          last_idx;
    logic [2:0]          idx;
    logic [AW-1:0]       ptr;
    logic [EVW-1:0]      snap;
    logic [WORD_W-1:0]   w0_q;
    logic [WORD_W-1:0]   w1_q;
    logic [LABEL_W-1:0]  nxt_q;
    logic                evt_hit;
    logic                rec_hit;
    logic                ptr_unused;

    assign ptr_unused = ^rdata[WORD_W-1:4+AW];

    // Event bit named by the record under test, and full match.
    assign evt_hit = snap[w0_q[8 +: EVB]];
    assign rec_hit = evt_hit && cond_ok;

    assign idle      = (st == E_IDLE);
    assign act_valid = (st == E_ACT);
    assign sw_go     = (st == E_IDLE) && sw_pend;
    assign cond_sel  = w0_q[15:8];
    assign cond_arg  = w1_q[15:8];

    // Program read address chosen by the current step.
    always_comb begin
        case (st)
            E_PTR_RD: rd_addr = AW'(cur_state) + AW'(1);
            E_F0:     rd_addr = ptr;
            E_F1:     rd_addr = ptr + AW'(1);
            E_F2:     rd_addr = ptr + AW'(2);
            default:  rd_addr = '0;
        endcase
    end

    // Step sequencer and all datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= E_INIT_RD;
            cur_state  <= '0;
            list_base  <= '0;
            delim_mode <= 1'b0;
            last_idx   <= '0;
            idx        <= '0;
            ptr        <= '0;
            snap       <= '0;
            w0_q       <= '0;
            w1_q       <= '0;
            nxt_q      <= '0;
            act_id     <= '0;
            act_par    <= '0;
        end else begin
            case (st)
                E_INIT_RD: st <= E_INIT_WT;
                E_INIT_WT: begin
                    cur_state <= rdata[LABEL_W-1:0];
                    st        <= E_PTR_RD;
                end
                E_PTR_RD: st <= E_PTR_WT;
                E_PTR_WT: begin
                    list_base  <= rdata[4 +: AW];
                    delim_mode <= rdata[3];
                    last_idx   <= rdata[2:0];
                    st         <= E_IDLE;
                end
                E_IDLE: begin
                    if (sw_pend) begin
                        st <= E_INIT_RD;
                    end else if (|evt_in) begin
                        snap <= evt_in;
                        ptr  <= list_base;
                        idx  <= '0;
                        st   <= E_F0;
                    end
                end
                E_F0: st <= E_F1;
                E_F1: begin
                    w0_q <= rdata;
                    if (delim_mode && rdata == LIST_END) st <= E_IDLE;
                    else                                 st <= E_F2;
                end
                E_F2: begin
                    w1_q <= rdata;
                    st   <= E_EVAL;
                end
                E_EVAL: begin
                    if (rec_hit) begin
                        act_id  <= w1_q[7:0];
                        act_par <= rdata;
                        nxt_q   <= w0_q[LABEL_W-1:0];
                        st      <= E_ACT;
                    end else if (!delim_mode && idx == last_idx) begin
                        st <= E_IDLE;
                    end else begin
                        idx <= idx + 3'd1;
                        ptr <= ptr + AW'(3);
                        st  <= E_F0;
                    end
                end
                E_ACT: begin
                    if (act_ack) begin
                        cur_state <= nxt_q;
                        st        <= E_PTR_RD;
                    end
                end
                default: st <= E_INIT_RD;
            endcase
        end
    end
endmodule

// File: rtl/xfsm_exec.sv
// Top of the transition-table executor: program store, bank control and
// engine. Host writes always target the bank that is not running.
module xfsm_exec #(
    parameter int AW  = 8,
    parameter int EVW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] evt_in,
    output logic [7:0]     cond_sel,
    output logic [7:0]     cond_arg,
    input  logic           cond_ok,
    output logic           act_valid,
    input  logic           act_ack,
    output logic [7:0]     act_id,
    output logic [15:0]    act_par,
    input  logic           host_we,
    input  logic [AW-1:0]  host_addr,
    input  logic [15:0]    host_wdata,
    input  logic           host_activate,
    output logic           act_bank,
    output logic [7:0]     cur_state,
    output logic           idle
);
    logic [AW-1:0] rd_addr;
    logic [15:0]   rdata;
    logic          sw_go;
    logic          sw_pend;

    xfsm_progmem #(.AW(AW), .DW(16), .NB(2)) u_mem (
        .clk   (clk),
        .we    (host_we),
        .wbank (~act_bank),
        .waddr (host_addr),
        .wdata (host_wdata),
        .rbank (act_bank),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    xfsm_bank_ctl u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .activate (host_activate),
        .sw_go    (sw_go),
        .act_bank (act_bank),
        .sw_pend  (sw_pend)
    );

    xfsm_engine #(.AW(AW), .EVW(EVW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .cond_ok   (cond_ok),
        .act_ack   (act_ack),
        .sw_pend   (sw_pend),
        .rdata     (rdata),
        .rd_addr   (rd_addr),
        .sw_go     (sw_go),
        .cond_sel  (cond_sel),
        .cond_arg  (cond_arg),
        .act_valid (act_valid),
        .act_id    (act_id),
        .act_par   (act_par),
        .cur_state (cur_state),
        .idle      (idle)
    );
endmodule

// File: rtl/xfsm_exec_chk.sv
// Protocol checks on the executor's ports, bound into every instance.
module xfsm_exec_chk #(
    parameter int EVW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [EVW-1:0] evt_in,
    input logic           act_valid,
    input logic           act_ack,
    input logic [7:0]     act_id,
    input logic [15:0]    act_par,
    input logic           act_bank,
    input logic [7:0]     cur_state,
    input logic           idle
);
    // R1: no action request straight out of reset.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !act_valid);

    // R8: a request holds its code and argument until acknowledged.
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_ack |=> act_valid && $stable(act_id) && $stable(act_par));

    // R8: the state label waits for the acknowledge.
    a_r8_state_wait: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && !act_ack |=> $stable(cur_state));

    // R9: never waiting for events while an action is pending.
    a_r9_no_sample_busy: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> !idle);

    // R7: idle with no event leaves the state label alone.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !(|evt_in) |=> $stable(cur_state));

    // R11: the running bank changes only out of the idle step.
    a_r11_swap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_bank) |-> $past(idle));
endmodule

bind xfsm_exec xfsm_exec_chk #(.EVW(EVW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .act_valid (act_valid),
    .act_ack   (act_ack),
    .act_id    (act_id),
    .act_par   (act_par),
    .act_bank  (act_bank),
    .cur_state (cur_state),
    .idle      (idle)
);

// File: tb/xfsm_exec_tb.sv
// Scoreboard bench: the driver queues expected actions, the monitor
// compares each request against the queue and acknowledges it.
module xfsm_exec_tb;
    localparam int AW  = 8;
    localparam int EVW = 16;

    typedef struct packed {
        logic [7:0]  id;
        logic [15:0] par;
    } act_exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [EVW-1:0] evt_in = '0;
    logic [7:0]     cond_sel, cond_arg;
    logic           cond_ok;
    logic           act_valid;
    logic           act_ack = 1'b0;
    logic [7:0]     act_id;
    logic [15:0]    act_par;
    logic           host_we = 1'b0;
    logic [AW-1:0]  host_addr = '0;
    logic [15:0]    host_wdata = '0;
    logic           host_activate = 1'b0;
    logic           act_bank;
    logic [7:0]     cur_state;
    logic           idle;

    int n_chk = 0;
    int n_fail = 0;
    int ack_dly = 1;
    act_exp_t exp_q[$];

    always #4 clk = ~clk;

    // Condition evaluator model: argument 0x55 is never satisfied.
    assign cond_ok = (cond_arg != 8'h55);

    xfsm_exec #(.AW(AW), .EVW(EVW)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .cond_sel(cond_sel), .cond_arg(cond_arg), .cond_ok(cond_ok),
        .act_valid(act_valid), .act_ack(act_ack), .act_id(act_id),
        .act_par(act_par), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_activate(host_activate),
        .act_bank(act_bank), .cur_state(cur_state), .idle(idle)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic push_exp(input logic [7:0] id, input logic [15:0] par);
        act_exp_t e;
        e.id = id; e.par = par;
        exp_q.push_back(e);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!idle) @(negedge clk);
    endtask

    // Pulse events from idle, wait for the scan to end, check the label.
    task automatic ev(input int bitn, input logic [7:0] exp_cur, input string req);
        wait_idle();
        evt_in = '0; evt_in[bitn] = 1'b1;
        @(negedge clk);
        evt_in = '0;
        wait_idle();
        check(cur_state == exp_cur, req, cur_state, exp_cur);
    endtask

    // Monitor: compare each request against the queue, then acknowledge.
    initial begin
        forever begin
            @(negedge clk);
            if (act_valid && !act_ack) begin
                logic [7:0] cur_seen;
                cur_seen = cur_state;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected action", act_id, 0);
                end else begin
                    act_exp_t e;
                    e = exp_q.pop_front();
                    check(act_id == e.id, "R8 act_id", act_id, e.id);
                    check(act_par == e.par, "R8 act_par", act_par, e.par);
                end
                repeat (ack_dly - 1) @(negedge clk);
                check(act_valid && cur_state == cur_seen, "R8 held before ack",
                      cur_state, cur_seen);
                act_ack = 1'b1;
                @(negedge clk);
                act_ack = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(act_valid == 1'b0, "R1 act_valid", act_valid, 0);
        check(act_bank == 1'b0, "R1 act_bank", act_bank, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(act_valid == 1'b0, "R1 act_valid after release", act_valid, 0);

        // Program A into bank 1 (bank 0 running).
        wr(0, 16'h0000);
        wr(1, 16'h0102);   // S0: base 16, count mode, 3 records
        wr(2, 16'h01C8);   // S1: base 28, delimiter mode
        wr(3, 16'h0400);   // S2: base 64, count mode, 1 record
        wr(16, 16'h0201); wr(17, 16'h5510); wr(18, 16'h1111);
        wr(19, 16'h0202); wr(20, 16'h0011); wr(21, 16'h2222);
        wr(22, 16'h0301); wr(23, 16'h0012); wr(24, 16'h3333);
        wr(25, 16'h0402); wr(26, 16'h0013); wr(27, 16'h4444);
        for (int k = 0; k < 9; k++) begin
            wr(28 + 3*k, 16'h0601);
            wr(29 + 3*k, 16'h5520 + 16'(k));
            wr(30 + 3*k, 16'(k));
        end
        wr(55, 16'h0700); wr(56, 16'h002A); wr(57, 16'hA5A5);
        wr(58, 16'hFFFF);
        wr(59, 16'h0802); wr(60, 16'h002F); wr(61, 16'h9999);
        wr(64, 16'h0100); wr(65, 16'h0030); wr(66, 16'h0303);

        @(negedge clk); host_activate = 1'b1;
        @(negedge clk); host_activate = 1'b0;
        wait_idle();
        while (!(idle && act_bank)) @(negedge clk);
        check(act_bank == 1'b1, "R11 bank swapped", act_bank, 1);
        check(cur_state == 8'd0, "R2 initial state", cur_state, 0);

        ev(4, 8'd0, "R3 record past count ignored");
        push_exp(8'h11, 16'h2222);
        ev(2, 8'd2, "R5 R6 first true record taken");
        ev(3, 8'd2, "R7 no match keeps state");
        push_exp(8'h30, 16'h0303);
        ev(1, 8'd0, "R7 rescan from first record");
        push_exp(8'h12, 16'h3333);
        ev(3, 8'd1, "R5 third record");
        ev(8, 8'd1, "R4 record past delimiter ignored");
        ev(6, 8'd1, "R6 all blocked conditions");
        push_exp(8'h2A, 16'hA5A5);
        ev(7, 8'd0, "R4 tenth record of delimited list");

        // Program B into bank 0 while bank 1 runs.
        wr(0, 16'h0001);
        wr(1, 16'h0100);
        wr(2, 16'h0100);
        wr(16, 16'h0001); wr(17, 16'h0040); wr(18, 16'h4444);

        // Pending action collides with activation and a stray event.
        ack_dly = 8;
        push_exp(8'h11, 16'h2222);
        wait_idle();
        evt_in = 16'h0004;
        @(negedge clk);
        evt_in = '0;
        while (!act_valid) @(negedge clk);
        @(negedge clk);
        host_activate = 1'b1; evt_in = 16'h0008;
        @(negedge clk);
        host_activate = 1'b0; evt_in = '0;
        check(act_valid == 1'b1, "R9 action still pending", act_valid, 1);
        check(act_bank == 1'b1, "R11 no swap while busy", act_bank, 1);
        while (!(idle && !act_bank)) @(negedge clk);
        check(act_bank == 1'b0, "R11 swap after ack", act_bank, 0);
        check(cur_state == 8'd1, "R11 new initial state", cur_state, 1);
        ack_dly = 1;
        push_exp(8'h40, 16'h4444);
        ev(0, 8'd1, "R10 written bank now runs");

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R8 all expected actions seen", exp_q.size(), 0);
        finish_run();
    end
endmodule